// File: doc/BRIEF.md
# Origin-Isolated Indirect Branch Target Buffer

This block is a direct-mapped target buffer for indirect branches in a core that runs mutually distrusting software on one pipeline. Each stored target carries the privilege level and the hardware thread that trained it. While isolation is on, a lookup returns a prediction only when the entry came from the same privilege level and the same thread as the request. Code in one context therefore cannot plant a target that another context will follow speculatively.

Two flush strobes clear the whole table in a single cycle. One is raised by the pipeline on a privilege change, such as a system call or an exception entry. The other is a barrier command that system software issues on a process switch. A one-bit configuration register turns the origin comparison on or off. Its value after reset is a build parameter, so a part can ship with isolation off and still be hardened later by software.

The lookup stream and the update stream both use valid-only handshakes. The block accepts a lookup or an update in every cycle and never applies back-pressure, so it has no ready output. The result stream also has no ready input: the consumer must take a result in the cycle it appears. The flush strobes and the configuration write are plain control pins.

Top module: `ibp_core`

## Requirements
- R1: Reset clears every entry's valid bit, drives `res_valid`, `res_hit` and `res_target` to 0, and loads the isolation bit (`iso_en`) with parameter `ISO_RST`.
- R2: A lookup presented with `lkp_valid` in cycle t produces `res_valid`=1 after the next clock edge. `res_hit` is 1 only when the entry at index `lkp_pc[7:2]` is valid and its stored tag equals `lkp_pc[31:8]`. On a hit `res_target` is the stored target; otherwise it is 0.
- R3: When isolation is on, an entry trained at one privilege level (`mode` 1 = kernel, 0 = user) never hits for a lookup at the other level.
- R4: When isolation is on, an entry trained by one hardware thread (`tid`) never hits for a lookup from a different thread.
- R5: When isolation is off, the mode and thread comparisons are skipped, and a tag match on a valid entry hits from any origin.
- R6: A `priv_switch` pulse invalidates all entries, so lookups after it miss until the table is retrained.
- R7: A `pred_barrier` pulse invalidates all entries in the same way.
- R8: A lookup in the same cycle as either flush strobe returns a miss.
- R9: An update in the same cycle as a flush is dropped.
- R10: An update writes the indexed entry whatever its previous origin was. The entry takes the updater's tag, target, mode and thread.
- R11: A lookup in the same cycle as an update to the same index sees the contents from before the update.
- R12: `cfg_wr_en` loads `cfg_wr_data` into the isolation bit. The new value applies to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_pc | input | 32 | Fetch PC of the indirect branch |
| lkp_mode | input | 1 | Current privilege level, 1 = kernel |
| lkp_tid | input | 1 | Requesting hardware thread |
| res_valid | output | 1 | Registered lookup result valid |
| res_hit | output | 1 | Prediction available |
| res_target | output | 32 | Predicted target, 0 on a miss |
| upd_valid | input | 1 | Resolved-branch update valid |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_mode | input | 1 | Privilege level of the trainer |
| upd_tid | input | 1 | Thread of the trainer |
| upd_target | input | 32 | Resolved target |
| priv_switch | input | 1 | Privilege-transition flush strobe |
| pred_barrier | input | 1 | Software barrier flush strobe |
| cfg_wr_en | input | 1 | Isolation bit write enable |
| cfg_wr_data | input | 1 | Isolation bit write value |
| iso_en | output | 1 | Current isolation setting |

## Verification
Directed lookups are made from a fixed trained entry under four origins: the same mode and thread, the other mode, the other thread, and an alias with a different tag at the same index. This separates the tag check from each origin check, and repeating the set with isolation off shows that the origin comparisons are really bypassed. Lookups that collide with an update, with either flush strobe, and with an update in the same cycle as a flush show the read-before-write and flush-priority ordering. A random phase then draws PCs from four tags so that aliasing is frequent, mixes in origins, updates, flushes and isolation writes, and compares every result against a bench model of the table.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
  typedef enum logic {
    MODE_USER   = 1'b0,
    MODE_KERNEL = 1'b1
  } priv_mode_e;
endpackage

// File: rtl/ibp_table.sv
module ibp_table #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 24,
  parameter int TID_W   = 1,
  parameter int TGT_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  ibp_pkg::priv_mode_e wr_mode,
  input  logic [TID_W-1:0]   wr_tid,
  input  logic [TGT_W-1:0]   wr_tgt,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_vld,
  output logic [TAG_W-1:0]   rd_tag,
  output ibp_pkg::priv_mode_e rd_mode,
  output logic [TID_W-1:0]   rd_tid,
  output logic [TGT_W-1:0]   rd_tgt
);
  logic [ENTRIES-1:0]  vld_q;
  logic [TAG_W-1:0]    tag_q  [ENTRIES];
  ibp_pkg::priv_mode_e mode_q [ENTRIES];
  logic [TID_W-1:0]    tid_q  [ENTRIES];
  logic [TGT_W-1:0]    tgt_q  [ENTRIES];

  // flush wins over a write to the same entry
  logic wr_go;
  assign wr_go = wr_en && !flush;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        vld_q[e] <= 1'b0;
      end else if (wr_go && wr_idx == IDX_W'(e)) begin
        vld_q[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      tag_q[wr_idx]  <= wr_tag;
      mode_q[wr_idx] <= wr_mode;
      tid_q[wr_idx]  <= wr_tid;
      tgt_q[wr_idx]  <= wr_tgt;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_mode = mode_q[rd_idx];
  assign rd_tid  = tid_q[rd_idx];
  assign rd_tgt  = tgt_q[rd_idx];
endmodule

// File: rtl/ibp_match.sv
module ibp_match #(
  parameter int TAG_W = 24,
  parameter int TID_W = 1,
  parameter int TGT_W = 32
) (
  input  logic                req,
  input  logic                flush,
  input  logic                iso,
  input  logic                ent_vld,
  input  logic [TAG_W-1:0]    ent_tag,
  input  ibp_pkg::priv_mode_e ent_mode,
  input  logic [TID_W-1:0]    ent_tid,
  input  logic [TGT_W-1:0]    ent_tgt,
  input  logic [TAG_W-1:0]    req_tag,
  input  ibp_pkg::priv_mode_e req_mode,
  input  logic [TID_W-1:0]    req_tid,
  output logic                hit,
  output logic [TGT_W-1:0]    tgt
);
  logic tag_ok, origin_ok;

  always_comb begin
    tag_ok    = ent_vld && (ent_tag == req_tag);
    origin_ok = !iso || ((ent_mode == req_mode) && (ent_tid == req_tid));
    hit       = req && !flush && tag_ok && origin_ok;
    tgt       = hit ? ent_tgt : '0;
  end
endmodule

// File: rtl/ibp_core.sv
module ibp_core #(
  parameter int   PC_W    = 32,
  parameter int   ENTRIES = 64,
  parameter int   TID_W   = 1,
  parameter logic ISO_RST = 1'b0,
  localparam int  IDX_W   = $clog2(ENTRIES),
  localparam int  TAG_W   = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lkp_valid,
  input  logic [PC_W-1:0]  lkp_pc,
  input  logic             lkp_mode,
  input  logic [TID_W-1:0] lkp_tid,
  output logic             res_valid,
  output logic             res_hit,
  output logic [PC_W-1:0]  res_target,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_mode,
  input  logic [TID_W-1:0] upd_tid,
  input  logic [PC_W-1:0]  upd_target,
  input  logic             priv_switch,
  input  logic             pred_barrier,
  input  logic             cfg_wr_en,
  input  logic             cfg_wr_data,
  output logic             iso_en
);
  import ibp_pkg::*;

  logic flush;
  assign flush = priv_switch || pred_barrier;

  always_ff @(posedge clk) begin
    if (rst)            iso_en <= ISO_RST;
    else if (cfg_wr_en) iso_en <= cfg_wr_data;
  end

  logic             e_vld;
  logic [TAG_W-1:0] e_tag;
  priv_mode_e       e_mode;
  logic [TID_W-1:0] e_tid;
  logic [PC_W-1:0]  e_tgt;

  ibp_table #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .TID_W(TID_W), .TGT_W(PC_W)
  ) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .wr_en   (upd_valid),
    .wr_idx  (upd_pc[IDX_W+1:2]),
    .wr_tag  (upd_pc[PC_W-1:IDX_W+2]),
    .wr_mode (priv_mode_e'(upd_mode)),
    .wr_tid  (upd_tid),
    .wr_tgt  (upd_target),
    .rd_idx  (lkp_pc[IDX_W+1:2]),
    .rd_vld  (e_vld),
    .rd_tag  (e_tag),
    .rd_mode (e_mode),
    .rd_tid  (e_tid),
    .rd_tgt  (e_tgt)
  );

  logic            hit_c;
  logic [PC_W-1:0] tgt_c;

  ibp_match #(.TAG_W(TAG_W), .TID_W(TID_W), .TGT_W(PC_W)) u_match (
    .req      (lkp_valid),
    .flush    (flush),
    .iso      (iso_en),
    .ent_vld  (e_vld),
    .ent_tag  (e_tag),
    .ent_mode (e_mode),
    .ent_tid  (e_tid),
    .ent_tgt  (e_tgt),
    .req_tag  (lkp_pc[PC_W-1:IDX_W+2]),
    .req_mode (priv_mode_e'(lkp_mode)),
    .req_tid  (lkp_tid),
    .hit      (hit_c),
    .tgt      (tgt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_target <= '0;
    end else begin
      res_valid  <= lkp_valid;
      res_hit    <= hit_c;
      res_target <= tgt_c;
    end
  end
endmodule

// File: rtl/ibp_chk.sv
module ibp_chk #(
  parameter int   PC_W    = 32,
  parameter logic ISO_RST = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            lkp_valid,
  input logic            upd_valid,
  input logic            priv_switch,
  input logic            pred_barrier,
  input logic            cfg_wr_en,
  input logic            cfg_wr_data,
  input logic            res_valid,
  input logic            res_hit,
  input logic [PC_W-1:0] res_target,
  input logic            iso_en
);
  logic rst_q, flushed_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) flushed_q <= 1'b0;
    else     flushed_q <= priv_switch || pred_barrier;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst_q |-> (!res_valid && !res_hit && iso_en == ISO_RST));

  // R2
  result_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(lkp_valid));

  // R2
  no_hit_without_req_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_hit);

  // R2
  miss_target_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> res_target == '0);

  // R8
  flush_cycle_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && (priv_switch || pred_barrier)) |=> !res_hit);

  // R9
  after_flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (flushed_q && lkp_valid) |=> !res_hit);

  // R12
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_wr_en) |-> iso_en == $past(cfg_wr_data));
endmodule

bind ibp_core ibp_chk #(.PC_W(PC_W), .ISO_RST(ISO_RST)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lkp_valid    (lkp_valid),
  .upd_valid    (upd_valid),
  .priv_switch  (priv_switch),
  .pred_barrier (pred_barrier),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_wr_data  (cfg_wr_data),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .res_target   (res_target),
  .iso_en       (iso_en)
);

// File: tb/ibp_core_test.sv
`timescale 1ns/1ps
module ibp_core_test;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_valid = 0, lkp_mode = 0, upd_valid = 0, upd_mode = 0;
  logic [31:0] lkp_pc = 0, upd_pc = 0, upd_target = 0;
  logic [0:0]  lkp_tid = 0, upd_tid = 0;
  logic        priv_switch = 0, pred_barrier = 0, cfg_wr_en = 0, cfg_wr_data = 0;
  logic        res_valid, res_hit, iso_en;
  logic [31:0] res_target;

  ibp_core uut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;

  bit          m_v   [N];
  logic [23:0] m_tag [N];
  bit          m_mode[N];
  bit          m_tid [N];
  logic [31:0] m_tgt [N];
  bit          m_iso;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] model_lookup(logic [31:0] pc, bit md, bit td);
    int i = int'(pc[7:2]);
    bit h = m_v[i] && m_tag[i] == pc[31:8] && (!m_iso || (m_mode[i] == md && m_tid[i] == td));
    if (priv_switch || pred_barrier) h = 0;
    return {h, h ? m_tgt[i] : 32'h0};
  endfunction

  // one clock: predict, advance model, compare, idle inputs
  task automatic step(input string req);
    logic [32:0] e = model_lookup(lkp_pc, lkp_mode, lkp_tid[0]);
    bit ev = lkp_valid;
    if (!ev) e = '0;
    @(posedge clk);
    if (priv_switch || pred_barrier) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (upd_valid) begin
      m_v[upd_pc[7:2]]    = 1;
      m_tag[upd_pc[7:2]]  = upd_pc[31:8];
      m_mode[upd_pc[7:2]] = upd_mode;
      m_tid[upd_pc[7:2]]  = upd_tid[0];
      m_tgt[upd_pc[7:2]]  = upd_target;
    end
    if (cfg_wr_en) m_iso = cfg_wr_data;
    @(negedge clk);
    chk(res_valid == ev, req, 64'(res_valid), 64'(ev));
    chk(res_hit == e[32], req, 64'(res_hit), 64'(e[32]));
    chk(res_target == e[31:0], req, 64'(res_target), 64'(e[31:0]));
    chk(iso_en == m_iso, req, 64'(iso_en), 64'(m_iso));
    lkp_valid = 0; upd_valid = 0; priv_switch = 0; pred_barrier = 0; cfg_wr_en = 0;
  endtask

  task automatic lookup(input logic [31:0] pc, input bit md, input bit td);
    lkp_valid = 1; lkp_pc = pc; lkp_mode = md; lkp_tid = td;
  endtask

  task automatic update(input logic [31:0] pc, input bit md, input bit td, input logic [31:0] t);
    upd_valid = 1; upd_pc = pc; upd_mode = md; upd_tid = td; upd_target = t;
  endtask

  localparam logic [31:0] PA = 32'h0012_3414;  // index 5
  localparam logic [31:0] PB = 32'h0099_9914;  // same index, other tag

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_iso = 1'b0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(res_valid == 0 && res_hit == 0, "R1", 64'({res_valid, res_hit}), 64'd0);
    chk(iso_en == 1'b0, "R1", 64'(iso_en), 64'd0);
    lookup(PA, 1, 0); step("R1");
    cfg_wr_en = 1; cfg_wr_data = 1; step("R12");
    update(PA, 1, 0, 32'hCAFE_0010); step("R10");
    lookup(PA, 1, 0); step("R2");
    lookup(PA, 0, 0); step("R3");
    lookup(PA, 1, 1); step("R4");
    lookup(PB, 1, 0); step("R2");
    cfg_wr_en = 1; cfg_wr_data = 0; step("R12");
    lookup(PA, 0, 1); step("R5");
    lookup(PA, 0, 0); step("R5");
    cfg_wr_en = 1; cfg_wr_data = 1; lookup(PA, 0, 1); step("R12");
    lookup(PA, 0, 1); step("R12");
    lookup(PA, 1, 0); update(PA, 0, 1, 32'hBEEF_0020); step("R11");
    lookup(PA, 1, 0); step("R10");
    lookup(PA, 0, 1); step("R10");
    priv_switch = 1; step("R6");
    lookup(PA, 0, 1); step("R6");
    update(PA, 0, 1, 32'h1111_0030); step("R7");
    lookup(PA, 0, 1); pred_barrier = 1; step("R8");
    lookup(PA, 0, 1); step("R7");
    update(PA, 0, 1, 32'h2222_0040); priv_switch = 1; step("R9");
    lookup(PA, 0, 1); step("R9");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      automatic int r = $urandom_range(0, 99);
      automatic logic [31:0] pc = {22'h0, 2'($urandom_range(0, 3)), 6'($urandom), 2'b00};
      lookup(pc, 1'($urandom), 1'($urandom));
      lkp_valid = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 9) < 4)
        update({22'h0, 2'($urandom_range(0, 3)), 6'($urandom), 2'b00},
               1'($urandom), 1'($urandom), $urandom);
      if (r < 2) priv_switch = 1;
      else if (r < 4) pred_barrier = 1;
      if ($urandom_range(0, 49) == 0) begin
        cfg_wr_en = 1; cfg_wr_data = 1'($urandom);
      end
      step("R2");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule